// File: doc/BRIEF.md
# Radix-2² Delay-Feedback Butterfly Pair

This block is the multiplier-free front half of one radix-4 stage in a single-path delay-feedback FFT pipeline. It accepts one complex sample per valid cycle in natural order and produces one partly transformed complex sample per valid cycle. Inside are two radix-2 butterflies in series. The first keeps an N/2-deep feedback line and the second keeps an N/4-deep one. The factor -j between them is applied by exchanging the real and imaginary parts and negating one of them. The pair therefore needs no multiplier, while the next stage keeps radix-4 multiplier counts.

A single modulo-N counter advances once per accepted sample and drives every phase decision. The top two bits of that counter pick pass or compute for the two butterflies. Each butterfly widens the data by one bit, so the result is two bits wider than the input. The stage that follows (twiddle multiplier, coefficient table, reordering) is supplied by the user. Input-valid gaps freeze the whole pair.

Top module: `r22_sdf_pair`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid is low after that edge, and the sample counter restarts at zero.
- R2: out_valid stays low until 3N/4 valid samples have been accepted. The accepted sample numbered 3N/4 (counting from zero) produces the first out_valid, one clock after the edge that takes it.
- R3: For output index q, let F = q div N, p = q mod N and t = p mod N/4. Let x be input frame F and define A = x[t]+x[t+N/2], B = x[t+N/4]+x[t+3N/4], C = x[t]-x[t+N/2] and D = x[t+N/4]-x[t+3N/4]. When p lies in [0, N/4), the output is A+B.
- R4: When p lies in [N/4, N/2), the output is A−B.
- R5: When p lies in [N/2, 3N/4), the output is C+(−j)·D, with real part Cr+Di and imaginary part Ci−Dr.
- R6: When p lies in [3N/4, N), the output is C−(−j)·D, with real part Cr−Di and imaginary part Ci+Dr.
- R7: A clock edge with in_valid low leaves the counter and both delay lines unchanged. After that edge out_valid is low and out_re/out_im hold their values.
- R8: Outputs are W+2 bits in two's complement. Full-scale inputs (all samples at the most positive value, or half the frame at the most negative value) give exact results with no wrap.
- R9: Once primed, every valid input edge gives out_valid high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample is present this cycle |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| out_valid | output | 1 | Output sample is present (registered) |
| out_re | output | W+2 | Output real part, signed |
| out_im | output | W+2 | Output imaginary part, signed |

## Verification
In the last quarter of the delayed frame, the second butterfly must apply the −j swap and perform its add/subtract in the same cycle, and the first butterfly is then emitting a stored difference. A wrong choice of phase bits corrupts exactly those samples, and the R5/R6 checks catch it. Random idle cycles fall inside these quarters during the first frames, so a stall that lands on a rotate-and-combine cycle must freeze both delay lines without skipping or repeating a rotation. Every out_valid sample is compared against bench-computed A/B/C/D combinations for its index.

// File: rtl/r22_pkg.sv
// Package r22_pkg: shared phase encoding for the radix-2^2 pair.
// Assumes nothing beyond IEEE 1800-2017.
package r22_pkg;
    // Pass/compute selector for one butterfly
    typedef enum logic {
        BF_PASS    = 1'b0,
        BF_COMPUTE = 1'b1
    } bf_phase_e;
endpackage

// File: rtl/r22_delay.sv
// r22_delay: enable-gated shift line of DEPTH words used as butterfly feedback.
// Assumes DEPTH >= 1. The contents are not reset; the control block
// guarantees that stale words never reach a valid output.
module r22_delay #(
    parameter int DEPTH = 8,
    parameter int DW    = 13
) (
    input  logic          clk,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stg [DEPTH];

    // First stage takes the new word when enabled
    always_ff @(posedge clk) begin
        if (en) stg[0] <= din;
    end

    genvar gi;
    generate
        for (gi = 1; gi < DEPTH; gi++) begin : g_stage
            // Each later stage shifts from its neighbour when enabled
            always_ff @(posedge clk) begin
                if (en) stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/r22_ctrl.sv
// r22_ctrl: modulo-N sample counter shared by both butterflies.
// Assumes N is a power of 4 and at least 16. The counter advances only on
// valid samples. Outputs: phase of each butterfly, the -j rotate strobe, and
// 'primed' once both delay lines hold real data.
module r22_ctrl
    import r22_pkg::*;
#(
    parameter int N = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    output bf_phase_e ph1,
    output bf_phase_e ph2,
    output logic      rot,
    output logic      primed
);
    localparam int           LG      = $clog2(N);
    localparam logic [LG-1:0] PRIME_C = LG'(3 * N / 4);

    logic [LG-1:0] cnt;
    logic          wrapped;

    // Sample counter: clears on reset, steps on each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    // Remembers that a full frame has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n)                         wrapped <= 1'b0;
        else if (adv && (cnt == {LG{1'b1}})) wrapped <= 1'b1;
    end

    // Phase decode: top bit for stage one, next bit for stage two
    always_comb begin
        ph1    = bf_phase_e'(cnt[LG-1]);
        ph2    = bf_phase_e'(cnt[LG-2]);
        rot    = ~cnt[LG-1] & cnt[LG-2];
        primed = wrapped | (cnt >= PRIME_C);
    end
endmodule

// File: rtl/r22_bf.sv
// r22_bf: one radix-2 delay-feedback butterfly with optional -j on its input.
// Assumes a signed IW-bit input and gives a combinational IW+1-bit output. In
// PASS it stores the input and forwards the delayed word. In COMPUTE it
// forwards head+input and stores head-input. 'rot' (re,im)->(im,-re) is
// applied to the input before the butterfly.
module r22_bf
    import r22_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 12
) (
    input  logic                 clk,
    input  logic                 en,
    input  bf_phase_e            phase,
    input  logic                 rot,
    input  logic signed [IW-1:0] in_re,
    input  logic signed [IW-1:0] in_im,
    output logic signed [IW:0]   out_re,
    output logic signed [IW:0]   out_im
);
    localparam int OW = IW + 1;

    logic signed [OW-1:0] xr, xi, yr, yi, hr, hi, pr, pi;
    logic [2*OW-1:0]      head_w, push_w;

    // Sign-extend and optionally rotate by -j
    always_comb begin
        xr = {in_re[IW-1], in_re};
        xi = {in_im[IW-1], in_im};
        if (rot) begin
            yr = xi;
            yi = -xr;
        end else begin
            yr = xr;
            yi = xi;
        end
    end

    r22_delay #(.DEPTH(DEPTH), .DW(2*OW)) u_line (
        .clk (clk),
        .en  (en),
        .din (push_w),
        .dout(head_w)
    );

    // Butterfly select: pass-through or add/subtract against the head word
    always_comb begin
        hr = head_w[2*OW-1:OW];
        hi = head_w[OW-1:0];
        if (phase == BF_COMPUTE) begin
            out_re = hr + yr;
            out_im = hi + yi;
            pr     = hr - yr;
            pi     = hi - yi;
        end else begin
            out_re = hr;
            out_im = hi;
            pr     = yr;
            pi     = yi;
        end
        push_w = {pr, pi};
    end
endmodule

// File: rtl/r22_sdf_pair.sv
// r22_sdf_pair: two cascaded delay-feedback butterflies (N/2 then N/4 deep)
// with a multiplier-free -j between them, and a registered output.
// Assumes N is a power of 4 (16, 64, 256, ...), continuous natural-order
// frames, and in_valid as the only flow control.
module r22_sdf_pair
    import r22_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_re,
    input  logic signed [W-1:0]  in_im,
    output logic                 out_valid,
    output logic signed [W+1:0]  out_re,
    output logic signed [W+1:0]  out_im
);
    localparam int D1 = N / 2;
    localparam int D2 = N / 4;

    bf_phase_e           ph1, ph2;
    logic                rot, primed;
    logic signed [W:0]   s1_re, s1_im;
    logic signed [W+1:0] s2_re, s2_im;

    r22_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .ph1   (ph1),
        .ph2   (ph2),
        .rot   (rot),
        .primed(primed)
    );

    r22_bf #(.DEPTH(D1), .IW(W)) u_bf1 (
        .clk   (clk),
        .en    (in_valid),
        .phase (ph1),
        .rot   (1'b0),
        .in_re (in_re),
        .in_im (in_im),
        .out_re(s1_re),
        .out_im(s1_im)
    );

    r22_bf #(.DEPTH(D2), .IW(W+1)) u_bf2 (
        .clk   (clk),
        .en    (in_valid),
        .phase (ph2),
        .rot   (rot),
        .in_re (s1_re),
        .in_im (s1_im),
        .out_re(s2_re),
        .out_im(s2_im)
    );

    // Output valid: a primed, accepted sample gives a result next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid & primed;
    end

    // Output data: loads on accepted samples, holds during stalls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_re <= '0;
            out_im <= '0;
        end else if (in_valid) begin
            out_re <= s2_re;
            out_im <= s2_im;
        end
    end
endmodule

// File: rtl/r22_sdf_pair_chk.sv
// r22_sdf_pair_chk: protocol checker for r22_sdf_pair, attached by bind.
// It keeps its own saturating count of accepted samples to judge priming.
module r22_sdf_pair_chk #(
    parameter int N = 16,
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W+1:0] out_re,
    input logic [W+1:0] out_im
);
    localparam int PRIME = 3 * N / 4;
    localparam int CW    = $clog2(N) + 1;

    logic [CW-1:0] nseen;

    // Saturating count of accepted samples since reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                nseen <= '0;
        else if (in_valid && (int'(nseen) < PRIME)) nseen <= nseen + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
    AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(nseen) < PRIME) |=> !out_valid); // R2
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_re) && $stable(out_im))); // R7
    AST_STREAM_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (int'(nseen) >= PRIME)) |=> out_valid); // R9
endmodule

bind r22_sdf_pair r22_sdf_pair_chk #(.N(N), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_re   (out_re),
    .out_im   (out_im)
);

// File: tb/r22_sdf_pair_bench.sv
module r22_sdf_pair_bench;
    localparam int N     = 16;
    localparam int W     = 12;
    localparam int NF    = 5;
    localparam int TOT   = NF * N;
    localparam int PRIME = 3 * N / 4;
    localparam int NOUT  = TOT - PRIME;
    localparam int QN    = N / 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_re = '0;
    logic signed [W-1:0] in_im = '0;
    logic                out_valid;
    logic signed [W+1:0] out_re, out_im;

    int checks = 0;
    int fails  = 0;
    int xr [TOT];
    int xi [TOT];
    int oidx = 0;
    int n_in = 0;
    int n_in_prev = 0;
    logic last_iv = 1'b0;
    logic mon_on = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    r22_sdf_pair #(.N(N), .W(W)) u_r22_sdf_pair (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected output for index q; sel 0 = real, 1 = imaginary
    function automatic int expect_val(input int q, input int sel);
        int b, p, t, qt, ar, ai, br, bi, cr, ci, dr, di;
        b  = (q / N) * N;
        p  = q % N;
        t  = p % QN;
        qt = p / QN;
        ar = xr[b+t] + xr[b+t+N/2];       ai = xi[b+t] + xi[b+t+N/2];
        br = xr[b+t+QN] + xr[b+t+3*QN];   bi = xi[b+t+QN] + xi[b+t+3*QN];
        cr = xr[b+t] - xr[b+t+N/2];       ci = xi[b+t] - xi[b+t+N/2];
        dr = xr[b+t+QN] - xr[b+t+3*QN];   di = xi[b+t+QN] - xi[b+t+3*QN];
        case (qt)
            0: return sel ? ai + bi : ar + br;
            1: return sel ? ai - bi : ar - br;
            2: return sel ? ci - dr : cr + di;
            default: return sel ? ci + dr : cr - di;
        endcase
    endfunction

    function automatic string qtag(input int q);
        string s;
        case ((q % N) / QN)
            0: s = "R3";
            1: s = "R4";
            2: s = "R5";
            default: s = "R6";
        endcase
        if (q / N == 1 || q / N == 2) s = {s, "/R8"};
        return s;
    endfunction

    // Monitor: valid timing (R2, R7, R9) and data (R3..R6, R8) at negedge
    always @(negedge clk) begin
        if (mon_on) begin
            check("R2/R7/R9 out_valid", int'(out_valid),
                  int'(last_iv && (n_in_prev >= PRIME)));
            if (out_valid) begin
                if (oidx < NOUT) begin
                    check({qtag(oidx), " re"}, int'(out_re), expect_val(oidx, 0));
                    check({qtag(oidx), " im"}, int'(out_im), expect_val(oidx, 1));
                end
                oidx++;
            end
            n_in_prev = n_in;
            if (in_valid) n_in++;
            last_iv = in_valid;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int g = 0; g < TOT; g++) begin
            int f, n;
            f = g / N;
            n = g % N;
            if (f == 1) begin
                xr[g] = 2047;  xi[g] = -2048;
            end else if (f == 2) begin
                xr[g] = (n < N/2) ? -2048 : 2047;
                xi[g] = (n < N/2) ? 2047 : -2048;
            end else begin
                xr[g] = int'($urandom % 4096) - 2048;
                xi[g] = int'($urandom % 4096) - 2048;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_re in reset", int'(out_re), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        mon_on = 1'b1;
        for (int g = 0; g < TOT; g++) begin
            if (g < 3 * N && ($urandom % 4) == 0) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_re = W'(xr[g]);
            in_im = W'(xi[g]);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R2/R9 output count", oidx, NOUT);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule